// File: doc/BRIEF.md
# DPLL Lock Calibration Sequencer

This block runs the calibration of a digital PLL that generates an interface clock from a bus clock. On `start` it derives a frequency window from the selected bus-clock slot and the target clock. The window is a low limit and a high limit. The block writes the window into a control word with a tune-enable bit set, then samples the PLL lock indication at a fixed interval. A lock only counts once it has stayed high for a full run of consecutive checks. When an attempt ends without a confirmed lock, the window is widened by one step and the next attempt begins. The high and low limits take turns being moved, and the step grows with the attempt number. There are at most eight attempts.

On success the tune-enable bit drops and the window stays as it was. After the eighth failed attempt a failure flag is raised. Either result flag, and the control word with it, holds until the next accepted start. The PLL itself lies outside the block. It reads `ctrl_word` and drives `lock`.

Top module: `dpll_cal_seq`

## Requirements
- R1: After reset, `ctrl_word` is zero and `busy`, `cal_ok` and `cal_fail` are low.
- R2: An accepted start loads the low limit as (bus MHz × 48) / target MHz, using integer division. `bus_slot` values 0, 1, 2 and 3 select 33, 40, 50 and 66 MHz. `fast_target` = 1 selects a 66 MHz target and 0 selects 50 MHz.
- R3: The start also loads the high limit as the low limit plus 2, plus a further 2 when `bus_slot` is 2 or 3.
- R4: `ctrl_word` carries the high limit in bits 31:16, the tune-enable bit in bit 8 and the low limit in bits 7:0. Bits 15:9 are zero. Tune-enable is 1 for the whole time `busy` is high.
- R5: During an attempt, `lock` is sampled once every WAIT_CYCLES cycles, for at most POLL_LIMIT samples. The attempt fails if none of these samples is high. With `lock` held low, the failure flag appears exactly 8 × WAIT_CYCLES × POLL_LIMIT clock edges after the start edge.
- R6: Once a sample sees lock, `lock` must stay high on each of the next HOLD_CHECKS cycles. Success is taken on the last of those cycles, so `cal_ok` appears WAIT_CYCLES + HOLD_CHECKS edges after the start edge when lock is high from the start. A low value on any of those cycles fails the attempt.
- R7: On success `cal_ok` rises, tune-enable clears and both frequency limits stay unchanged.
- R8: After failed attempt n (counting from 0), an odd n lowers the low limit by n>>1 and an even n raises the high limit by n>>1. The window never narrows while `busy` is high.
- R9: The eighth failed attempt raises `cal_fail`. `ctrl_word` then holds the fully widened window with tune-enable still set.
- R10: `cal_ok` and `cal_fail` are never high together. A result flag and `ctrl_word` hold until the next start, and changes on `lock` or `bus_slot` do not disturb them. A start while `busy` is ignored. A start in the idle or done state clears the flags and begins a new calibration.
- R11: `busy` is high from the edge that accepts a start until the edge that raises a result flag, and a result flag only rises out of `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration (ignored while busy) |
| bus_slot | input | 2 | Bus clock slot: 0=33, 1=40, 2=50, 3=66 MHz |
| fast_target | input | 1 | 1 selects the 66 MHz target, 0 the 50 MHz target |
| lock | input | 1 | Lock indication from the PLL |
| ctrl_word | output | 32 | {high limit, 7'b0, tune-enable, low limit} |
| busy | output | 1 | Calibration in progress |
| cal_ok | output | 1 | Calibration succeeded (held until next start) |
| cal_fail | output | 1 | All attempts failed (held until next start) |

## Verification
On every cycle the assertions check these relations:
- tune-enable is set while busy and clear once the success flag is up;
- the window never narrows during a calibration;
- a fresh calibration opens a window of width 2 or 4;
- a success follows a high lock sample;
- the result and control word stay frozen until the next start.

Some behaviour only the bench scenarios can show:
- the exact low-limit value for each slot and target;
- which attempt succeeds under a given PLL model;
- the precise edge on which a success or a poll-exhausted failure appears;
- the collapse of an attempt when lock drops on its last hold check;
- the ignoring of a start during calibration.

// File: rtl/dpll_cal_seq.sv
module dpll_cal_seq #(
  parameter int POLL_LIMIT  = 20480,
  parameter int HOLD_CHECKS = 4096,
  parameter int WAIT_CYCLES = 16,
  parameter int MAX_TRIES   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  bus_slot,
  input  logic        fast_target,
  input  logic        lock,
  output logic [31:0] ctrl_word,
  output logic        busy,
  output logic        cal_ok,
  output logic        cal_fail
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int HW = $clog2(HOLD_CHECKS + 1);
  localparam int WW = $clog2(WAIT_CYCLES + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HOLD, S_OK, S_FAIL} st_t;
  st_t st;

  logic [15:0]   f_hi;
  logic [7:0]    f_lo;
  logic          tune;
  logic [PW-1:0] poll_cnt;
  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] wait_cnt;
  logic [TW-1:0] try_cnt;

  logic [12:0] mhz;
  always_comb begin
    case (bus_slot)
      2'd0:    mhz = 13'd33;
      2'd1:    mhz = 13'd40;
      2'd2:    mhz = 13'd50;
      default: mhz = 13'd66;
    endcase
  end

  logic [7:0] lo_init, hi_init, step;
  assign lo_init = 8'((mhz * 13'd48) / (fast_target ? 13'd66 : 13'd50));
  assign hi_init = lo_init + 8'd2 + (bus_slot[1] ? 8'd2 : 8'd0);
  assign step    = 8'(try_cnt >> 1);

  logic go, wait_end, poll_end, hold_end, miss;
  assign busy     = (st == S_WAIT) || (st == S_HOLD);
  assign go       = start && !busy;
  assign wait_end = wait_cnt == WW'(WAIT_CYCLES - 1);
  assign poll_end = poll_cnt == PW'(POLL_LIMIT - 1);
  assign hold_end = hold_cnt == HW'(HOLD_CHECKS - 1);
  assign miss     = ((st == S_WAIT) && wait_end && !lock && poll_end) ||
                    ((st == S_HOLD) && !lock);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      f_hi     <= '0;
      f_lo     <= '0;
      tune     <= 1'b0;
      poll_cnt <= '0;
      hold_cnt <= '0;
      wait_cnt <= '0;
      try_cnt  <= '0;
    end else if (go) begin
      st       <= S_WAIT;
      f_lo     <= lo_init;
      f_hi     <= 16'(hi_init);
      tune     <= 1'b1;
      poll_cnt <= '0;
      hold_cnt <= '0;
      wait_cnt <= '0;
      try_cnt  <= '0;
    end else if (miss) begin
      if (try_cnt[0]) f_lo <= f_lo - step;
      else            f_hi <= f_hi + 16'(step);
      poll_cnt <= '0;
      hold_cnt <= '0;
      wait_cnt <= '0;
      if (try_cnt == TW'(MAX_TRIES - 1)) begin
        st <= S_FAIL;
      end else begin
        try_cnt <= try_cnt + 1'b1;
        st      <= S_WAIT;
      end
    end else begin
      case (st)
        S_WAIT: begin
          if (wait_end) begin
            wait_cnt <= '0;
            if (lock) begin
              st       <= S_HOLD;
              hold_cnt <= '0;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (hold_end) begin
            st   <= S_OK;
            tune <= 1'b0;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ctrl_word = {f_hi, 7'd0, tune, f_lo};
  assign cal_ok    = st == S_OK;
  assign cal_fail  = st == S_FAIL;
endmodule

module dpll_cal_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        lock,
  input logic [31:0] ctrl_word,
  input logic        busy,
  input logic        cal_ok,
  input logic        cal_fail
);
  a_r4_tune_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ctrl_word[8]);

  a_r7_ok_tune_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ok |-> !ctrl_word[8]);

  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_ok || cal_fail) && !start |=> $stable(ctrl_word) && $stable(cal_ok) && $stable(cal_fail));

  a_r8_window_widens: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> (ctrl_word[31:16] >= $past(ctrl_word[31:16])) &&
                            (ctrl_word[7:0] <= $past(ctrl_word[7:0])));

  a_r3_initial_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ctrl_word[31:16] - 16'(ctrl_word[7:0]) == 16'd2) ||
                    (ctrl_word[31:16] - 16'(ctrl_word[7:0]) == 16'd4));

  a_r6_ok_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_ok) |-> $past(lock));

  a_r11_flag_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_ok) || $rose(cal_fail) |-> $past(busy));
endmodule

bind dpll_cal_seq dpll_cal_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .lock(lock), .ctrl_word(ctrl_word),
  .busy(busy), .cal_ok(cal_ok), .cal_fail(cal_fail)
);

// File: tb/test_dpll_cal_seq.sv
module test_dpll_cal_seq;
  localparam int W = 3;
  localparam int P = 10;
  localparam int H = 6;
  localparam int NV = 8;
  localparam int VSLOT [NV] = '{0, 1, 2, 3, 0, 2, 3, 1};
  localparam int VFAST [NV] = '{1, 0, 1, 0, 0, 0, 1, 1};
  localparam int VMIN  [NV] = '{2, 5, 4, 9, 12, 13, 6, 3};
  localparam int VOK   [NV] = '{1, 1, 1, 1, 0, 1, 1, 1};
  localparam int VK    [NV] = '{0, 5, 0, 6, 8, 7, 4, 3};

  logic clk = 0, rst_n = 0, start = 0, fast_target = 0;
  logic [1:0] bus_slot = 0;
  logic [31:0] ctrl_word;
  logic busy, cal_ok, cal_fail, lock;
  logic [1:0] mode = 0;
  logic lvl = 0, tog = 0;
  int minw = 0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tog <= ~tog;

  assign lock = (mode == 2'd0) ? (ctrl_word[8] &&
                 (int'(ctrl_word[31:16]) - int'(ctrl_word[7:0]) >= minw)) :
                (mode == 2'd1) ? 1'b0 : (mode == 2'd2) ? tog : lvl;

  dpll_cal_seq #(.POLL_LIMIT(P), .HOLD_CHECKS(H), .WAIT_CYCLES(W), .MAX_TRIES(8)) i_dpll_cal_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_slot(bus_slot),
    .fast_target(fast_target), .lock(lock), .ctrl_word(ctrl_word),
    .busy(busy), .cal_ok(cal_ok), .cal_fail(cal_fail));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int slot, int fast, int nfail, bit tune);
    int mhz, fl, fh;
    case (slot)
      0: mhz = 33;
      1: mhz = 40;
      2: mhz = 50;
      default: mhz = 66;
    endcase
    fl = mhz * 48 / (fast ? 66 : 50);
    fh = fl + 2 + ((slot > 1) ? 2 : 0);
    for (int n = 0; n < nfail; n++) begin
      if (n % 2) fl -= n / 2;
      else       fh += n / 2;
    end
    return {16'(fh), 7'd0, tune, 8'(fl)};
  endfunction

  task automatic do_start(input int slot, input int fast);
    @(negedge clk);
    bus_slot = 2'(slot);
    fast_target = fast[0];
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 1000 && !(cal_ok || cal_fail); i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog: actual busy=%0d expected a result flag", busy);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl_word == 0 && !busy && !cal_ok && !cal_fail, "R1 reset state",
        {ctrl_word[31:3], busy, cal_ok, cal_fail}, 32'd0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      mode = 0;
      minw = VMIN[v];
      do_start(VSLOT[v], VFAST[v]);
      chk(ctrl_word == exp_word(VSLOT[v], VFAST[v], 0, 1'b1), "R2 R3 R4 initial window",
          ctrl_word, exp_word(VSLOT[v], VFAST[v], 0, 1'b1));
      chk(busy && !cal_ok && !cal_fail, "R11 busy after start", {29'd0, busy, cal_ok, cal_fail}, 32'd4);
      wait_done();
      chk(cal_ok == VOK[v][0] && cal_fail == !VOK[v][0] && !busy, "R5 R8 R9 outcome",
          {30'd0, cal_ok, cal_fail}, {30'd0, VOK[v][0], !VOK[v][0]});
      chk(ctrl_word == exp_word(VSLOT[v], VFAST[v], VK[v], !VOK[v][0]), "R7 R8 R9 final word",
          ctrl_word, exp_word(VSLOT[v], VFAST[v], VK[v], !VOK[v][0]));
    end

    mode = 3;
    lvl = 1;
    do_start(2, 1);
    repeat (W + H - 1) @(negedge clk);
    chk(!cal_ok && busy, "R6 no success before last hold check", {30'd0, busy, cal_ok}, 32'd2);
    @(negedge clk);
    chk(cal_ok && !busy, "R6 success on last hold check", {30'd0, busy, cal_ok}, 32'd1);
    chk(ctrl_word == exp_word(2, 1, 0, 1'b0), "R7 tune cleared, limits kept", ctrl_word, exp_word(2, 1, 0, 1'b0));

    lvl = 0;
    bus_slot = 2'd0;
    repeat (20) @(negedge clk);
    chk(cal_ok && !cal_fail && ctrl_word == exp_word(2, 1, 0, 1'b0), "R10 result held",
        ctrl_word, exp_word(2, 1, 0, 1'b0));

    mode = 1;
    do_start(1, 1);
    chk(!cal_ok && busy, "R10 start clears flag", {30'd0, busy, cal_ok}, 32'd2);
    repeat (3 * W * P - 1) @(negedge clk);
    chk(ctrl_word == exp_word(1, 1, 0, 1'b1), "R8 high limit before third failure",
        ctrl_word, exp_word(1, 1, 0, 1'b1));
    @(negedge clk);
    chk(ctrl_word == exp_word(1, 1, 3, 1'b1), "R8 high limit raised after third failure",
        ctrl_word, exp_word(1, 1, 3, 1'b1));
    bus_slot = 2'd3;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(ctrl_word == exp_word(1, 1, 3, 1'b1) && busy, "R10 start while busy ignored",
        ctrl_word, exp_word(1, 1, 3, 1'b1));
    repeat (8 * W * P - 1 - (3 * W * P + 1)) @(negedge clk);
    chk(!cal_fail && busy, "R5 no failure before poll budget", {30'd0, busy, cal_fail}, 32'd2);
    @(negedge clk);
    chk(cal_fail && !busy && !cal_ok, "R5 R9 failure at exact edge", {29'd0, busy, cal_ok, cal_fail}, 32'd1);
    chk(ctrl_word == exp_word(1, 1, 8, 1'b1), "R9 fully widened window", ctrl_word, exp_word(1, 1, 8, 1'b1));

    mode = 3;
    lvl = 1;
    do_start(3, 0);
    chk(!cal_fail && busy, "R10 restart from failure", {30'd0, busy, cal_fail}, 32'd2);
    repeat (W + H - 1) @(negedge clk);
    lvl = 0;
    @(negedge clk);
    chk(busy && !cal_ok, "R6 drop on last hold check fails attempt", {30'd0, busy, cal_ok}, 32'd2);
    mode = 1;
    wait_done();
    chk(cal_fail && ctrl_word == exp_word(3, 0, 8, 1'b1), "R9 failure after hold drop",
        ctrl_word, exp_word(3, 0, 8, 1'b1));

    mode = 2;
    do_start(0, 1);
    wait_done();
    chk(cal_fail && !cal_ok, "R6 R10 toggling lock never accepted", {30'd0, cal_ok, cal_fail}, 32'd1);
    chk(ctrl_word == exp_word(0, 1, 8, 1'b1), "R9 toggling lock final word", ctrl_word, exp_word(0, 1, 8, 1'b1));

    finish_run();
  end
endmodule